// File: doc/BRIEF.md
# Serial Register Port with Three- or Four-Wire Data Lanes

This block is the slave side of a small serial configuration link. A host frames each access with an active-low enable and shifts a command bit, a three-bit register address, four unused slots and an eight-bit data byte over a serial clock. Every field goes least significant bit first. Behind the link sits a register file of seven live bytes: one configuration byte, three per-colour gain bytes and three per-colour offset bytes. Address 7 is reserved.

Read data can leave on either of two lanes. A host that shares one bidirectional data line holds the mode pin low during the address phase, and the byte comes back on that shared line. A host that uses separate in and out lines lets the mode pin float high, and the block then drives the byte onto the mode pin itself. Pad drivers are outside the block: each lane is a value plus an output enable.

All serial inputs pass through a synchronizer into the system clock, and edges are found there. The system clock must be at least 2·(SYNC_STAGES+2) times the serial clock. A configuration write that clears the power-down bit (bit 7) starts a wake timer of WAKE_CYCLES system clocks. The ready output stays low until that timer has run out.

The frame state machine has six states:
- ST_IDLE: enable released.
- ST_CMD: waiting for the read/write bit.
- ST_ADDR: three address bits.
- ST_GAP: four ignored slots.
- ST_DATA: eight data bits.
- ST_HOLD: frame complete; later clocks are ignored.

Its transitions are:
- ST_IDLE→ST_CMD when the synchronized enable goes low.
- ST_CMD→ST_ADDR on the first rising edge.
- ST_ADDR→ST_GAP on the third address edge.
- ST_GAP→ST_DATA on the fourth gap edge.
- ST_DATA→ST_HOLD on the eighth data edge, which commits a write.
- Any state→ST_IDLE when the enable goes high.

Top module: `serial_cfg_port`

## Requirements
- R1: A frame carries bits in this order, each sampled on a rising serial clock edge: slot 0 is read/write (1 = read, 0 = write), slots 1–3 are address bits A0..A2, slots 4–7 are ignored, and slots 8–15 are data bits D0..D7. A write commits on the 16th rising edge.
- R2: The address map is 0 configuration, 1/2/3 red/green/blue gain and 4/5/6 red/green/blue offset. After reset, configuration holds 0x80 and every other register holds 0x00. Gain and offset outputs are packed red in bits [7:0], green in [15:8] and blue in [23:16].
- R3: A read returns the addressed register LSB first. Each bit is launched after a falling serial clock edge, starting with the falling edge that opens slot 8.
- R4: The mode pin level at the A2 rising edge picks the read lane. Low sends data on ser_dout with ser_dout_oe. High sends data on ser_mode_out with ser_mode_oe. Both enables are never high together.
- R5: A lane enable is high only in the data phase of a read frame. It is never high during slots 0–7 and never during a write.
- R6: Releasing the enable drops both lane enables and returns to idle. A frame released before its 16th rising edge leaves every register unchanged.
- R7: A write to address 7 changes no register. A read from address 7 returns 0x00.
- R8: cfg_ready is low while configuration bit 7 is 1. A configuration write that clears bit 7 from the power-down state holds cfg_ready low for WAKE_CYCLES clocks before it rises. A write with bit 7 clear while already awake leaves cfg_ready high.
- R9: Register outputs change exactly SYNC_STAGES+1 system clocks after the 16th rising serial clock edge reaches the pins.
- R10: Serial clock edges after the 16th in a frame are ignored until the enable is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from host |
| ser_en_n | input | 1 | Active-low frame enable |
| ser_din | input | 1 | Serial data from host (shared line or separate in line) |
| ser_mode_in | input | 1 | Level of the shared out/mode pin |
| ser_dout | output | 1 | Read bit for the shared data line |
| ser_dout_oe | output | 1 | Drive enable for the shared data line |
| ser_mode_out | output | 1 | Read bit for the out/mode pin |
| ser_mode_oe | output | 1 | Drive enable for the out/mode pin |
| cfg_q | output | 8 | Configuration register |
| gain_q | output | 24 | Gain registers, red/green/blue |
| ofs_q | output | 24 | Offset registers, red/green/blue |
| cfg_ready | output | 1 | Powered up and wake delay elapsed |

## Verification
Every serial edge reaches the state machine SYNC_STAGES+1 system clocks after the host drives it. A write therefore shows on the register outputs on the third clock after the 16th rising edge. A read bit shows on its lane three clocks after a falling edge. Lane enables drop three clocks after the enable is released. The bench holds each serial clock level for four system clocks and samples read bits and enables just before it drives the next rising edge. It checks the write latency edge by edge: still old two clocks after the rising edge, new on the third. The wake check samples cfg_ready well inside the WAKE_CYCLES window and again well past it.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_GAP,
        ST_DATA,
        ST_HOLD
    } scp_state_t;

    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned GAP_SLOTS = 4;
    localparam int unsigned CH_COUNT  = 3;
    localparam int unsigned SLOT_W    = $clog2(DATA_W);
    localparam int unsigned NUM_REGS  = 1 << ADDR_W;
    localparam int unsigned NUM_LIVE  = NUM_REGS - 1;
    localparam int unsigned PD_BIT    = 7;

    localparam logic [ADDR_W-1:0] A_CFG      = 3'd0;
    localparam logic [ADDR_W-1:0] A_GAIN0    = 3'd1;
    localparam logic [ADDR_W-1:0] A_OFS0     = 3'd4;
    localparam logic [ADDR_W-1:0] A_RESV     = 3'd7;
    localparam logic [DATA_W-1:0] CFG_RESET  = 8'h80;

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int unsigned      WIDTH     = 4,
    parameter int unsigned      STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) begin
                chain_q[s] <= RESET_VAL;
            end
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < int'(STAGES); s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/scp_frame_fsm.sv
module scp_frame_fsm
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sen_n_s,
    input  logic              din_s,
    input  logic              mode_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              lane_bit,
    output logic              lane3_oe,
    output logic              lane4_oe,
    output scp_state_t        fsm_state,
    output logic              fsm_rd
);

    scp_state_t        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              sclk_d_q;
    logic              rise, fall, active;

    logic              rw_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wsh_q;
    logic [DATA_W-1:0] rbyte_q;
    logic              wire4_q;
    logic              drive_q;
    logic              bit_q;

    assign active = ~sen_n_s;
    assign rise   = sclk_s & ~sclk_d_q;
    assign fall   = ~sclk_s & sclk_d_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            slot_q   <= '0;
            sclk_d_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            slot_q   <= slot_d;
            sclk_d_q <= sclk_s;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        if (!active) begin
            state_d = ST_IDLE;
            slot_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_CMD;
                    slot_d  = '0;
                end
                ST_CMD: begin
                    if (rise) begin
                        state_d = ST_ADDR;
                        slot_d  = '0;
                    end
                end
                ST_ADDR: begin
                    if (rise) begin
                        if (slot_q == SLOT_W'(ADDR_W - 1)) begin
                            state_d = ST_GAP;
                            slot_d  = '0;
                        end else begin
                            slot_d = slot_q + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (rise) begin
                        if (slot_q == SLOT_W'(GAP_SLOTS - 1)) begin
                            state_d = ST_DATA;
                            slot_d  = '0;
                        end else begin
                            slot_d = slot_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (rise) begin
                        if (slot_q == SLOT_W'(DATA_W - 1)) begin
                            state_d = ST_HOLD;
                            slot_d  = '0;
                        end else begin
                            slot_d = slot_q + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    state_d = ST_HOLD;
                end
                default: begin
                    state_d = ST_IDLE;
                    slot_d  = '0;
                end
            endcase
        end
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_q    <= 1'b0;
            addr_q  <= '0;
            wsh_q   <= '0;
            rbyte_q <= '0;
            wire4_q <= 1'b0;
            drive_q <= 1'b0;
            bit_q   <= 1'b0;
        end else if (!active) begin
            drive_q <= 1'b0;
        end else begin
            if (state_q == ST_CMD && rise) begin
                rw_q <= din_s;
            end
            if (state_q == ST_ADDR && rise) begin
                addr_q <= {din_s, addr_q[ADDR_W-1:1]};
                if (slot_q == SLOT_W'(ADDR_W - 1)) begin
                    wire4_q <= mode_s;
                end
            end
            if (state_q == ST_GAP && rise && slot_q == '0) begin
                rbyte_q <= rd_data;
            end
            if (state_q == ST_DATA && rise) begin
                wsh_q <= {din_s, wsh_q[DATA_W-1:1]};
            end
            if (state_q == ST_DATA && fall && rw_q) begin
                drive_q <= 1'b1;
                bit_q   <= rbyte_q[slot_q];
            end
        end
    end

    // outputs
    always_comb begin
        reg_addr  = addr_q;
        wr_en     = active && (state_q == ST_DATA) && rise &&
                    (slot_q == SLOT_W'(DATA_W - 1)) && !rw_q;
        wr_data   = {din_s, wsh_q[DATA_W-1:1]};
        lane_bit  = bit_q;
        lane3_oe  = drive_q & ~wire4_q;
        lane4_oe  = drive_q &  wire4_q;
        fsm_state = state_q;
        fsm_rd    = rw_q;
    end

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
    import scp_pkg::*;
#(
    parameter int unsigned WAKE_CYCLES = 1_250_000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [DATA_W-1:0]            rd_data,
    output logic [DATA_W-1:0]            cfg_q,
    output logic [CH_COUNT*DATA_W-1:0]   gain_q,
    output logic [CH_COUNT*DATA_W-1:0]   ofs_q,
    output logic                         cfg_ready
);

    localparam int unsigned WAKE_W = $clog2(WAKE_CYCLES + 1);

    logic [DATA_W-1:0] live_q [NUM_LIVE];
    logic [WAKE_W-1:0] wake_q;
    logic              wake_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NUM_LIVE); i++) begin
                live_q[i] <= (i == 0) ? CFG_RESET : '0;
            end
        end else if (wr_en && addr != A_RESV) begin
            live_q[addr] <= wr_data;
        end
    end

    always_comb begin
        if (addr == A_RESV) begin
            rd_data = '0;
        end else begin
            rd_data = live_q[addr];
        end
    end

    assign cfg_q = live_q[A_CFG];

    generate
        for (genvar ch = 0; ch < int'(CH_COUNT); ch++) begin : g_chan
            assign gain_q[ch*DATA_W +: DATA_W] = live_q[int'(A_GAIN0) + ch];
            assign ofs_q[ch*DATA_W +: DATA_W]  = live_q[int'(A_OFS0) + ch];
        end
    endgenerate

    assign wake_start = wr_en && (addr == A_CFG) &&
                        !wr_data[PD_BIT] && live_q[A_CFG][PD_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_q <= '0;
        end else if (wake_start) begin
            wake_q <= WAKE_W'(WAKE_CYCLES);
        end else if (wake_q != '0) begin
            wake_q <= wake_q - 1'b1;
        end
    end

    assign cfg_ready = !live_q[A_CFG][PD_BIT] && (wake_q == '0);

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import scp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WAKE_CYCLES = 1_250_000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_clk,
    input  logic                       ser_en_n,
    input  logic                       ser_din,
    input  logic                       ser_mode_in,
    output logic                       ser_dout,
    output logic                       ser_dout_oe,
    output logic                       ser_mode_out,
    output logic                       ser_mode_oe,
    output logic [DATA_W-1:0]          cfg_q,
    output logic [CH_COUNT*DATA_W-1:0] gain_q,
    output logic [CH_COUNT*DATA_W-1:0] ofs_q,
    output logic                       cfg_ready
);

    localparam int unsigned     PIN_W     = 4;
    localparam logic [PIN_W-1:0] PIN_RESET = 4'b0010;

    logic [PIN_W-1:0]  pins_s;
    logic              sclk_s, sen_n_s, din_s, mode_s;
    logic [ADDR_W-1:0] reg_addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              lane_bit;
    scp_state_t        fsm_state;
    logic              fsm_rd;

    scp_sync #(
        .WIDTH     (PIN_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (PIN_RESET)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_mode_in, ser_din, ser_en_n, ser_clk}),
        .sync_out (pins_s)
    );

    assign {mode_s, din_s, sen_n_s, sclk_s} = pins_s;

    scp_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .sen_n_s   (sen_n_s),
        .din_s     (din_s),
        .mode_s    (mode_s),
        .rd_data   (rd_data),
        .reg_addr  (reg_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .lane_bit  (lane_bit),
        .lane3_oe  (ser_dout_oe),
        .lane4_oe  (ser_mode_oe),
        .fsm_state (fsm_state),
        .fsm_rd    (fsm_rd)
    );

    scp_regfile #(
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .cfg_q     (cfg_q),
        .gain_q    (gain_q),
        .ofs_q     (ofs_q),
        .cfg_ready (cfg_ready)
    );

    assign ser_dout     = lane_bit;
    assign ser_mode_out = lane_bit;

endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk
    import scp_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sen_n_s,
    input logic                       ser_dout_oe,
    input logic                       ser_mode_oe,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic [DATA_W-1:0]          cfg_q,
    input logic [CH_COUNT*DATA_W-1:0] gain_q,
    input logic [CH_COUNT*DATA_W-1:0] ofs_q,
    input logic                       cfg_ready,
    input scp_state_t                 fsm_state,
    input logic                       fsm_rd
);

    assert_commit_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (fsm_state == ST_DATA && !fsm_rd));

    assert_lane_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_dout_oe && ser_mode_oe));

    assert_drive_in_read_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_dout_oe || ser_mode_oe) |->
            (fsm_rd && (fsm_state == ST_DATA || fsm_state == ST_HOLD)));

    assert_release_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sen_n_s |=> !(ser_dout_oe || ser_mode_oe));

    assert_regs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cfg_q) && $stable(gain_q) && $stable(ofs_q)));

    assert_reserved_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == A_RESV) |=>
            ($stable(cfg_q) && $stable(gain_q) && $stable(ofs_q)));

    assert_wake_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_q[PD_BIT]) |-> !cfg_ready);

endmodule

bind serial_cfg_port serial_cfg_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sen_n_s     (sen_n_s),
    .ser_dout_oe (ser_dout_oe),
    .ser_mode_oe (ser_mode_oe),
    .wr_en       (wr_en),
    .reg_addr    (reg_addr),
    .cfg_q       (cfg_q),
    .gain_q      (gain_q),
    .ofs_q       (ofs_q),
    .cfg_ready   (cfg_ready),
    .fsm_state   (fsm_state),
    .fsm_rd      (fsm_rd)
);

// File: tb/test_serial_cfg_port.sv
`timescale 1ns/1ps
module test_serial_cfg_port;

    localparam int WAKE = 60;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_en_n = 1'b1;
    logic        ser_din = 1'b0;
    logic        ser_mode_in = 1'b0;
    logic        ser_dout, ser_dout_oe, ser_mode_out, ser_mode_oe;
    logic [7:0]  cfg_q;
    logic [23:0] gain_q, ofs_q;
    logic        cfg_ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [7:0] model [8];

    always #4 clk = ~clk;

    serial_cfg_port #(.SYNC_STAGES(2), .WAKE_CYCLES(WAKE)) i_serial_cfg_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
        .ser_din(ser_din), .ser_mode_in(ser_mode_in), .ser_dout(ser_dout),
        .ser_dout_oe(ser_dout_oe), .ser_mode_out(ser_mode_out),
        .ser_mode_oe(ser_mode_oe), .cfg_q(cfg_q), .gain_q(gain_q),
        .ofs_q(ofs_q), .cfg_ready(cfg_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_out(input logic [2:0] a);
        case (a)
            3'd0: reg_out = cfg_q;
            3'd1: reg_out = gain_q[7:0];
            3'd2: reg_out = gain_q[15:8];
            3'd3: reg_out = gain_q[23:16];
            3'd4: reg_out = ofs_q[7:0];
            3'd5: reg_out = ofs_q[15:8];
            3'd6: reg_out = ofs_q[23:16];
            default: reg_out = 8'h00;
        endcase
    endfunction

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    // nslots rising edges; data-phase read bits sampled before each rise
    task automatic do_frame(input bit rd, input logic [2:0] a, input logic [7:0] d,
                            input bit four, input int nslots, input bit lat_chk,
                            output logic [7:0] got, output bit quiet, output bit lane_ok,
                            output bit lat_ok);
        logic [15:0] bits;
        logic [7:0]  old_v;
        bits    = {d, 4'b0000, a, rd};
        got     = 8'h00;
        quiet   = 1'b1;
        lane_ok = 1'b1;
        lat_ok  = 1'b1;
        old_v   = reg_out(a);
        ser_mode_in = four;
        ser_clk  = 1'b0;
        ser_en_n = 1'b0;
        half_wait();
        for (int s = 0; s < nslots; s++) begin
            ser_clk = 1'b0;
            ser_din = (s < 16) ? bits[4'(s)] : 1'($urandom_range(0, 1));
            half_wait();
            if (s < 8 && (ser_dout_oe || ser_mode_oe)) quiet = 1'b0;
            if (!rd && (ser_dout_oe || ser_mode_oe)) quiet = 1'b0;
            if (rd && s >= 8 && s < 16) begin
                got[3'(s - 8)] = four ? ser_mode_out : ser_dout;
                if (four ? !(ser_mode_oe && !ser_dout_oe) : !(ser_dout_oe && !ser_mode_oe))
                    lane_ok = 1'b0;
            end
            ser_clk = 1'b1;
            if (lat_chk && s == 15) begin
                @(negedge clk);
                @(negedge clk);
                if (reg_out(a) !== old_v) lat_ok = 1'b0;
                @(negedge clk);
                if (reg_out(a) !== d) lat_ok = 1'b0;
                repeat (HALF - 3) @(negedge clk);
            end else begin
                half_wait();
            end
        end
        ser_clk = 1'b0;
        half_wait();
        ser_en_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit four);
        logic [7:0] g; bit q, l, t;
        do_frame(1'b0, a, d, four, 16, 1'b0, g, q, l, t);
        if (a != 3'd7) model[a] = d;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input bit four);
        logic [7:0] g; bit q, l, t;
        do_frame(1'b1, a, 8'h00, four, 16, 1'b0, g, q, l, t);
        check(req, 32'(g), 32'(model[a]));
        check("R5 no drive in address phase", 32'(q), 32'd1);
        check("R4 lane select", 32'(l), 32'd1);
    endtask

    task automatic all_regs(input string req);
        for (int a = 0; a < 7; a++) check(req, 32'(reg_out(3'(a))), 32'(model[a]));
    endtask

    initial begin
        logic [7:0] g; bit q, l, t;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        model[0] = 8'h80;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state
        all_regs("R2 reset value");
        check("R8 ready low in power-down", 32'(cfg_ready), 32'd0);
        check("R5 idle lanes off", 32'({ser_dout_oe, ser_mode_oe}), 32'd0);

        // write with latency check, three-wire
        do_frame(1'b0, 3'd1, 8'hA5, 1'b0, 16, 1'b1, g, q, l, t);
        model[1] = 8'hA5;
        check("R9 commit latency", 32'(t), 32'd1);
        check("R1 write gain red", 32'(gain_q[7:0]), 32'hA5);
        check("R5 no drive on write", 32'(q), 32'd1);
        rd_chk("R3 read three-wire", 3'd1, 1'b0);
        rd_chk("R4 read four-wire", 3'd1, 1'b1);

        wr(3'd6, 8'h3C, 1'b1);
        check("R2 offset blue slot", 32'(ofs_q), 32'h3C0000);
        rd_chk("R3 read offset blue", 3'd6, 1'b0);

        // reserved address
        do_frame(1'b0, 3'd7, 8'hFF, 1'b0, 16, 1'b0, g, q, l, t);
        all_regs("R7 reserved write ignored");
        do_frame(1'b1, 3'd7, 8'h00, 1'b1, 16, 1'b0, g, q, l, t);
        check("R7 reserved reads zero", 32'(g), 32'h00);

        // aborted frames
        do_frame(1'b0, 3'd2, 8'h77, 1'b0, 10, 1'b0, g, q, l, t);
        check("R6 abort at 10 slots", 32'(gain_q[15:8]), 32'(model[2]));
        do_frame(1'b0, 3'd2, 8'h77, 1'b1, 15, 1'b0, g, q, l, t);
        check("R6 abort at 15 slots", 32'(gain_q[15:8]), 32'(model[2]));
        do_frame(1'b1, 3'd1, 8'h00, 1'b0, 12, 1'b0, g, q, l, t);
        check("R6 lanes off after release", 32'({ser_dout_oe, ser_mode_oe}), 32'd0);

        // extra slots
        do_frame(1'b0, 3'd3, 8'h5A, 1'b0, 24, 1'b0, g, q, l, t);
        model[3] = 8'h5A;
        check("R10 extra slots ignored", 32'(gain_q[23:16]), 32'h5A);

        // wake sequence
        wr(3'd0, 8'h05, 1'b0);
        repeat (20) @(negedge clk);
        check("R8 ready held during wake", 32'(cfg_ready), 32'd0);
        repeat (WAKE + 10) @(negedge clk);
        check("R8 ready after wake", 32'(cfg_ready), 32'd1);
        wr(3'd0, 8'h07, 1'b1);
        check("R8 awake rewrite keeps ready", 32'(cfg_ready), 32'd1);
        check("R1 cfg value", 32'(cfg_q), 32'h07);
        wr(3'd0, 8'h80, 1'b0);
        check("R8 power-down drops ready", 32'(cfg_ready), 32'd0);

        // constrained random mix
        for (int n = 0; n < 40; n++) begin
            logic [2:0] a;
            logic [7:0] d;
            bit four;
            a    = 3'($urandom_range(0, 7));
            d    = 8'($urandom_range(0, 255));
            four = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 1) == 1) rd_chk("R3 random read", a, four);
            else wr(a, d, four);
        end
        all_regs("R2 final register image");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule